// File: doc/BRIEF.md
# NAND Flash Read Command Sequencer

This block turns a one-shot read request into the byte-level traffic of an 8-bit asynchronous NAND flash bus. It drives chip enable, the command and address latch enables, the write and read strobes and the outgoing data byte. It watches the ready/busy pin and hands every byte it reads to a consumer through a valid/ready stream. Three operations exist. An identification read returns five bytes. A spare-area read returns the out-of-band bytes that follow the main data of one page. A page read first fetches that spare area and then jumps back to column zero with a random-data-output command, all under one chip-enable assertion, to stream the main data.

How many column and row address bytes to send, the page size, and the low and high time of each strobe are run-time inputs. The block samples them when it accepts a request. A consumer that stalls the stream stalls the bus, because the next read strobe is not issued until the held byte is taken. A `done` pulse marks the release of chip enable at the end of every operation.

Top module: `nand_rd_seq`

## Requirements
- R1: A spare or page read begins with command byte 0x00, then the column address bytes, then the row address bytes, then command byte 0x30. Both addresses go out least significant byte first.
- R2: The number of column address bytes follows `cfg_col_bytes` and the number of row address bytes follows `cfg_row_bytes`. A value of 0 is treated as 1, and a value above the built maximum is treated as that maximum.
- R3: After the 0x30 byte the block polls ready/busy for busy for at most BUSY_POLLS cycles. When the window expires without busy it moves straight on to waiting for ready. No read strobe is issued while ready/busy is low, and with no busy phase the first read strobe comes at least BUSY_POLLS cycles after the 0x30 byte.
- R4: A spare read starts at a column equal to the page size and returns page size / 32 bytes, in column order.
- R5: A page read returns the spare bytes first. It then sends command 0x05, two address bytes of 0x00, and command 0xE0, and returns page-size bytes starting at column 0.
- R6: An identification read (`req_op` = 0) sends command 0x90 and one address byte 0x00, then returns five bytes.
- R7: Chip enable goes low when a request is accepted and stays low without a break until the operation ends. `done` pulses for one cycle as it goes high, exactly once per operation.
- R8: A command byte is driven with CLE high and ALE low. An address byte is driven with ALE high and CLE low. Both are low during reads.
- R9: Each write or read strobe stays low for max(cfg_strobe_low, 2) cycles and then high for at least max(cfg_strobe_high, 2) cycles.
- R10: A request is accepted only while `req_ready` is high, which is only when idle. Operation codes are 0 = ID, 1 = page, 2 = spare. A request with code 3, or one made while busy, has no effect.
- R11: A byte on the stream stays valid and unchanged until `out_ready` takes it, and no byte is lost or repeated under backpressure.
- R12: After reset, chip enable and both strobes are high, CLE and ALE are low, `req_ready` is high and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_col_bytes | input | $clog2(COL_MAX+1) | Column address byte count |
| cfg_row_bytes | input | $clog2(ROW_MAX+1) | Row address byte count |
| cfg_page_size | input | 8*COL_MAX | Main-area size in bytes |
| cfg_strobe_low | input | TW | Strobe low time in cycles |
| cfg_strobe_high | input | TW | Strobe high time in cycles |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Operation code |
| req_row | input | 8*ROW_MAX | Page (row) address |
| req_ready | output | 1 | Idle, request can be taken |
| out_valid | output | 1 | Read byte available |
| out_data | output | 8 | Read byte |
| out_ready | input | 1 | Consumer takes the byte |
| done | output | 1 | One-cycle pulse at chip-enable release |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data byte toward the flash |
| nand_dq_oe | output | 1 | Drive enable for nand_dq_o |
| nand_dq_i | input | 8 | Data byte from the flash |
| nand_rb_n | input | 1 | Ready/busy, low while busy |

## Verification
A wrong sequencer state shows up on the bus within one strobe period as a wrong byte in the command/address log, or as a latch enable raised in the wrong phase. A wrong byte counter shows up only at the end of an operation, as a short or long returned stream or an extra chip-enable release. The bench models the flash so that each returned byte encodes its own row and column. A lost return to column zero, a wrong spare offset or a dropped byte under backpressure therefore turns into a data mismatch at the first affected byte. Timer faults appear as measured strobe widths on the very first bus cycle.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;

   typedef enum logic [1:0] {
      OP_ID    = 2'd0,
      OP_PAGE  = 2'd1,
      OP_SPARE = 2'd2,
      OP_NONE  = 2'd3
   } nand_op_e;

   typedef enum logic [3:0] {
      S_IDLE, S_CMD, S_COL, S_ROW, S_CONF, S_BUSY, S_RDY, S_RD_SPR,
      S_RCMD, S_RCOL, S_RCONF, S_RD_MAIN, S_IDADR, S_RD_ID, S_END
   } seq_state_e;

   typedef enum logic [1:0] {
      BK_NONE, BK_CMD, BK_ADDR, BK_READ
   } byte_kind_e;

   localparam logic [7:0] CMD_READ    = 8'h00;
   localparam logic [7:0] CMD_CONFIRM = 8'h30;
   localparam logic [7:0] CMD_RAND    = 8'h05;
   localparam logic [7:0] CMD_RAND_GO = 8'hE0;
   localparam logic [7:0] CMD_ID      = 8'h90;

   function automatic byte_kind_e kind_of(seq_state_e s);
      case (s)
         S_CMD, S_CONF, S_RCMD, S_RCONF:    return BK_CMD;
         S_COL, S_ROW, S_RCOL, S_IDADR:     return BK_ADDR;
         S_RD_SPR, S_RD_MAIN, S_RD_ID:      return BK_READ;
         default:                           return BK_NONE;
      endcase
   endfunction

endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rb_n,
   output logic rb_s
);
   if (STAGES == 0) begin : g_bypass
      assign rb_s = rb_n;
   end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q[0] <= 1'b1;
         else        sh_q[0] <= rb_n;
      end
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q[i] <= 1'b1;
            else        sh_q[i] <= sh_q[i-1];
         end
      end
      assign rb_s = sh_q[STAGES-1];
   end
endmodule

// File: rtl/nand_strobe_timer.sv
module nand_strobe_timer #(
   parameter int TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [TW-1:0] low_len,
   input  logic [TW-1:0] high_len,
   output logic          active,
   output logic          strobe_low,
   output logic          sample,
   output logic          fin
);
   localparam logic [TW-1:0] MIN_T = TW'(2);

   logic          busy_q, phase_q;
   logic [TW-1:0] cnt_q, lo_eff, hi_eff;

   assign lo_eff = (low_len  < MIN_T) ? MIN_T : low_len;
   assign hi_eff = (high_len < MIN_T) ? MIN_T : high_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         phase_q <= 1'b0;
         cnt_q   <= '0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q  <= 1'b1;
            phase_q <= 1'b0;
            cnt_q   <= lo_eff - TW'(1);
         end
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - TW'(1);
      end else if (!phase_q) begin
         phase_q <= 1'b1;
         cnt_q   <= hi_eff - TW'(1);
      end else begin
         busy_q <= 1'b0;
      end
   end

   assign active     = busy_q;
   assign strobe_low = busy_q && !phase_q;
   assign sample     = busy_q && !phase_q && (cnt_q == '0);
   assign fin        = busy_q &&  phase_q && (cnt_q == '0);
endmodule

// File: rtl/nand_rd_seq.sv
module nand_rd_seq
   import nand_rd_pkg::*;
#(
   parameter int COL_MAX     = 2,
   parameter int ROW_MAX     = 3,
   parameter int TW          = 4,
   parameter int BUSY_POLLS  = 100,
   parameter int SYNC_STAGES = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [$clog2(COL_MAX+1)-1:0]   cfg_col_bytes,
   input  logic [$clog2(ROW_MAX+1)-1:0]   cfg_row_bytes,
   input  logic [8*COL_MAX-1:0]           cfg_page_size,
   input  logic [TW-1:0]                  cfg_strobe_low,
   input  logic [TW-1:0]                  cfg_strobe_high,
   input  logic                           req_valid,
   input  logic [1:0]                     req_op,
   input  logic [8*ROW_MAX-1:0]           req_row,
   output logic                           req_ready,
   output logic                           out_valid,
   output logic [7:0]                     out_data,
   input  logic                           out_ready,
   output logic                           done,
   output logic                           nand_ce_n,
   output logic                           nand_cle,
   output logic                           nand_ale,
   output logic                           nand_we_n,
   output logic                           nand_re_n,
   output logic [7:0]                     nand_dq_o,
   output logic                           nand_dq_oe,
   input  logic [7:0]                     nand_dq_i,
   input  logic                           nand_rb_n
);
   localparam int PS_W = 8 * COL_MAX;
   localparam int ROW_W = 8 * ROW_MAX;
   localparam int CC_W = $clog2(COL_MAX + 1);
   localparam int RC_W = $clog2(ROW_MAX + 1);
   localparam int PW   = $clog2(BUSY_POLLS + 1);

   if (COL_MAX < 1 || COL_MAX > 4) begin : g_bad_col
      $error("COL_MAX must lie in 1..4");
   end
   if (ROW_MAX < 1 || ROW_MAX > 4) begin : g_bad_row
      $error("ROW_MAX must lie in 1..4");
   end
   if (TW < 2) begin : g_bad_tw
      $error("TW must be at least 2");
   end
   if (BUSY_POLLS < 1) begin : g_bad_polls
      $error("BUSY_POLLS must be at least 1");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
      $error("SYNC_STAGES must lie in 0..3");
   end

   seq_state_e       st;
   nand_op_e         op_q;
   byte_kind_e       kind;
   logic [PS_W-1:0]  col_sr, ps_q, cnt, spare_len;
   logic [ROW_W-1:0] row_sr;
   logic [CC_W-1:0]  ncol_q, ncol_eff;
   logic [RC_W-1:0]  nrow_q, nrow_eff;
   logic [PW-1:0]    poll_q;
   logic [7:0]       out_q;
   logic             out_v, ce_q, done_q, rb_s;
   logic             go, tmr_active, tmr_low, tmr_sample, tmr_fin;

   assign kind = kind_of(st);

   assign ncol_eff = (cfg_col_bytes == '0) ? CC_W'(1) :
                     (cfg_col_bytes > CC_W'(COL_MAX)) ? CC_W'(COL_MAX) : cfg_col_bytes;
   assign nrow_eff = (cfg_row_bytes == '0) ? RC_W'(1) :
                     (cfg_row_bytes > RC_W'(ROW_MAX)) ? RC_W'(ROW_MAX) : cfg_row_bytes;
   assign spare_len = (ps_q[PS_W-1:5] == '0) ? PS_W'(1) : (ps_q >> 5);

   nand_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .rb_n(nand_rb_n), .rb_s(rb_s)
   );

   assign go = (kind != BK_NONE) && !tmr_active && !((kind == BK_READ) && out_v);

   nand_strobe_timer #(.TW(TW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(go),
      .low_len(cfg_strobe_low), .high_len(cfg_strobe_high),
      .active(tmr_active), .strobe_low(tmr_low),
      .sample(tmr_sample), .fin(tmr_fin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         op_q   <= OP_ID;
         col_sr <= '0;
         row_sr <= '0;
         ps_q   <= '0;
         ncol_q <= CC_W'(1);
         nrow_q <= RC_W'(1);
         cnt    <= '0;
         poll_q <= '0;
         out_q  <= '0;
         out_v  <= 1'b0;
         ce_q   <= 1'b1;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (out_v && out_ready) out_v <= 1'b0;
         if (tmr_sample && kind == BK_READ) begin
            out_q <= nand_dq_i;
            out_v <= 1'b1;
         end
         case (st)
            S_IDLE: if (req_valid && req_op != OP_NONE) begin
               op_q   <= nand_op_e'(req_op);
               col_sr <= cfg_page_size;
               row_sr <= req_row;
               ps_q   <= cfg_page_size;
               ncol_q <= ncol_eff;
               nrow_q <= nrow_eff;
               ce_q   <= 1'b0;
               st     <= S_CMD;
            end
            S_CMD: if (tmr_fin) begin
               st  <= (op_q == OP_ID) ? S_IDADR : S_COL;
               cnt <= PS_W'(ncol_q - CC_W'(1));
            end
            S_COL: if (tmr_fin) begin
               col_sr <= col_sr >> 8;
               if (cnt == '0) begin
                  st  <= S_ROW;
                  cnt <= PS_W'(nrow_q - RC_W'(1));
               end else cnt <= cnt - PS_W'(1);
            end
            S_ROW: if (tmr_fin) begin
               row_sr <= row_sr >> 8;
               if (cnt == '0) st <= S_CONF;
               else           cnt <= cnt - PS_W'(1);
            end
            S_CONF: if (tmr_fin) begin
               st     <= S_BUSY;
               poll_q <= '0;
            end
            S_BUSY: begin
               if (!rb_s || poll_q == PW'(BUSY_POLLS - 1)) st <= S_RDY;
               else poll_q <= poll_q + PW'(1);
            end
            S_RDY: if (rb_s) begin
               st  <= S_RD_SPR;
               cnt <= spare_len - PS_W'(1);
            end
            S_RD_SPR: if (tmr_fin) begin
               if (cnt == '0) st <= (op_q == OP_PAGE) ? S_RCMD : S_END;
               else           cnt <= cnt - PS_W'(1);
            end
            S_RCMD: if (tmr_fin) begin
               st  <= S_RCOL;
               cnt <= PS_W'(1);
            end
            S_RCOL: if (tmr_fin) begin
               if (cnt == '0) st <= S_RCONF;
               else           cnt <= cnt - PS_W'(1);
            end
            S_RCONF: if (tmr_fin) begin
               st  <= S_RD_MAIN;
               cnt <= ps_q - PS_W'(1);
            end
            S_RD_MAIN: if (tmr_fin) begin
               if (cnt == '0) st <= S_END;
               else           cnt <= cnt - PS_W'(1);
            end
            S_IDADR: if (tmr_fin) begin
               st  <= S_RD_ID;
               cnt <= PS_W'(4);
            end
            S_RD_ID: if (tmr_fin) begin
               if (cnt == '0) st <= S_END;
               else           cnt <= cnt - PS_W'(1);
            end
            S_END: begin
               ce_q   <= 1'b1;
               done_q <= 1'b1;
               st     <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      nand_dq_o = 8'h00;
      case (st)
         S_CMD:   nand_dq_o = (op_q == OP_ID) ? CMD_ID : CMD_READ;
         S_CONF:  nand_dq_o = CMD_CONFIRM;
         S_RCMD:  nand_dq_o = CMD_RAND;
         S_RCONF: nand_dq_o = CMD_RAND_GO;
         S_COL:   nand_dq_o = col_sr[7:0];
         S_ROW:   nand_dq_o = row_sr[7:0];
         default: nand_dq_o = 8'h00;
      endcase
   end

   assign nand_cle   = (kind == BK_CMD);
   assign nand_ale   = (kind == BK_ADDR);
   assign nand_dq_oe = nand_cle || nand_ale;
   assign nand_we_n  = !(tmr_low && nand_dq_oe);
   assign nand_re_n  = !(tmr_low && kind == BK_READ);
   assign nand_ce_n  = ce_q;
   assign done       = done_q;
   assign req_ready  = (st == S_IDLE);
   assign out_valid  = out_v;
   assign out_data   = out_q;
endmodule

// File: rtl/nand_rd_seq_chk.sv
module nand_rd_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_ready,
   input logic       out_valid,
   input logic [7:0] out_data,
   input logic       out_ready,
   input logic       done,
   input logic       nand_ce_n,
   input logic       nand_cle,
   input logic       nand_ale,
   input logic       nand_we_n,
   input logic       nand_re_n,
   input logic       nand_rb_n
);
   // R8
   latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(nand_cle && nand_ale));

   // R8
   read_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_re_n |-> (!nand_cle && !nand_ale));

   // R7
   strobe_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

   // R7
   done_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (nand_ce_n && !$past(nand_ce_n)));

   // R10
   idle_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (nand_we_n && nand_re_n));

   // R11
   stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R9
   we_min_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nand_we_n) |=> !nand_we_n);

   // R9
   re_min_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nand_re_n) |=> !nand_re_n);

   // R3
   no_read_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nand_re_n) |-> nand_rb_n);
endmodule

bind nand_rd_seq nand_rd_seq_chk u_chk (.*);

// File: tb/tb_nand_rd_seq.sv
module tb_nand_rd_seq;
   import nand_rd_pkg::*;

   localparam int BUSY_POLLS = 100;
   localparam int WDOG = 150000;

   typedef struct packed {
      logic [1:0]  op;
      logic [1:0]  ncol;
      logic [1:0]  nrow;
      logic [23:0] row;
      logic [15:0] ps;
      logic [7:0]  blen;
      logic [3:0]  lo;
      logic [3:0]  hi;
      logic        bp;
      logic        poke;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 2'd2, 2'd3, 24'h000000, 16'd64,   8'd0,  4'd2, 4'd2, 1'b0, 1'b0},
      '{2'd2, 2'd2, 2'd3, 24'h012345, 16'd512,  8'd20, 4'd2, 4'd2, 1'b0, 1'b0},
      '{2'd1, 2'd2, 2'd2, 24'h00BEEF, 16'd256,  8'd30, 4'd3, 4'd2, 1'b1, 1'b0},
      '{2'd1, 2'd1, 2'd1, 24'h0000A7, 16'd64,   8'd10, 4'd0, 4'd1, 1'b0, 1'b0},
      '{2'd2, 2'd2, 2'd3, 24'h7F00C3, 16'd1024, 8'd0,  4'd2, 4'd3, 1'b1, 1'b0},
      '{2'd0, 2'd2, 2'd3, 24'h000000, 16'd64,   8'd0,  4'd5, 4'd4, 1'b1, 1'b0},
      '{2'd1, 2'd0, 2'd3, 24'h3A5C11, 16'd128,  8'd5,  4'd2, 4'd2, 1'b0, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_col_bytes = 2'd2;
   logic [1:0]  cfg_row_bytes = 2'd3;
   logic [15:0] cfg_page_size = 16'd64;
   logic [3:0]  cfg_strobe_low = 4'd2;
   logic [3:0]  cfg_strobe_high = 4'd2;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = 2'd0;
   logic [23:0] req_row = '0;
   logic        req_ready, out_valid, out_ready, done;
   logic [7:0]  out_data;
   logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
   logic [7:0]  nand_dq_o, nand_dq_i;
   logic        nand_rb_n;

   always #10 clk = ~clk;

   nand_rd_seq dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_col_bytes(cfg_col_bytes), .cfg_row_bytes(cfg_row_bytes),
      .cfg_page_size(cfg_page_size), .cfg_strobe_low(cfg_strobe_low),
      .cfg_strobe_high(cfg_strobe_high),
      .req_valid(req_valid), .req_op(req_op), .req_row(req_row), .req_ready(req_ready),
      .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready), .done(done),
      .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
      .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
      .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_rb_n(nand_rb_n)
   );

   int tests = 0;
   int fails = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                  req, what, act, act, exp, exp);
      end
   endtask

   // ---------------- flash model ----------------
   function automatic logic [7:0] dbyte(logic [23:0] row, logic [15:0] col);
      return col[7:0] ^ 8'(col[15:8] << 3) ^ row[7:0] ^ row[15:8] ^ row[23:16] ^ 8'h5A;
   endfunction

   function automatic logic [7:0] idbyte(int i);
      case (i)
         0: return 8'hA1;
         1: return 8'h3C;
         2: return 8'h77;
         3: return 8'h0E;
         default: return 8'hB2;
      endcase
   endfunction

   int          cur_ncol = 2, cur_blen = 0, exp_lo = 2, exp_hi = 2;
   logic [1:0]  log_k [32];
   logic [7:0]  log_b [32];
   int          log_n = 0;
   logic [7:0]  ab [8];
   int          an = 0;
   logic        id_mode = 1'b0;
   int          id_idx = 0;
   logic [23:0] dev_row = '0;
   logic [15:0] col_ptr = '0;
   logic        we_prev = 1'b1, re_prev = 1'b1, ce_prev = 1'b1;
   int          we_lo_run = 0, we_hi_run = 1000, re_lo_run = 0, re_hi_run = 1000;
   int          strobe_err = 0, busy_err = 0, ce_rises = 0;
   int          cyc = 0, conf_cyc = 0, gap = -1;
   bit          gap_pend = 1'b0;
   int          bdelay = 0, blen = 0;
   logic        rb_q = 1'b1;

   assign nand_rb_n = rb_q;
   always_comb nand_dq_i = id_mode ? idbyte(id_idx) : dbyte(dev_row, col_ptr);

   always @(posedge clk) begin
      cyc++;
      if (nand_we_n == 1'b0) begin
         if (we_prev) begin
            if (we_hi_run < exp_hi) strobe_err++;
         end
         we_lo_run++;
      end else begin
         if (!we_prev) begin
            if (we_lo_run != exp_lo) strobe_err++;
            we_lo_run = 0;
            we_hi_run = 0;
            if (!nand_ce_n && log_n < 32) begin
               log_k[log_n] = nand_cle ? (nand_ale ? 2'd3 : 2'd1) : (nand_ale ? 2'd2 : 2'd0);
               log_b[log_n] = nand_dq_o;
               log_n++;
            end
            if (nand_cle) begin
               case (nand_dq_o)
                  8'h00, 8'h05: an = 0;
                  8'h90: begin an = 0; id_mode = 1'b1; id_idx = 0; end
                  8'h30: begin
                     id_mode = 1'b0;
                     col_ptr = {(cur_ncol > 1) ? ab[1] : 8'h00, ab[0]};
                     dev_row = '0;
                     for (int k = 0; k < 3; k++)
                        if (cur_ncol + k < an) dev_row[8*k +: 8] = ab[cur_ncol + k];
                     conf_cyc = cyc;
                     gap_pend = 1'b1;
                     bdelay = 2;
                     blen = cur_blen;
                  end
                  8'hE0: col_ptr = {ab[1], ab[0]};
                  default: ;
               endcase
            end else if (nand_ale && an < 8) begin
               ab[an] = nand_dq_o;
               an++;
            end
         end
         we_hi_run++;
      end
      if (nand_re_n == 1'b0) begin
         if (re_prev) begin
            if (re_hi_run < exp_hi) strobe_err++;
            if (gap_pend) begin gap = cyc - conf_cyc; gap_pend = 1'b0; end
         end
         if (!rb_q) busy_err++;
         re_lo_run++;
      end else begin
         if (!re_prev) begin
            if (re_lo_run != exp_lo) strobe_err++;
            re_lo_run = 0;
            re_hi_run = 0;
            if (id_mode) id_idx++;
            else col_ptr = col_ptr + 16'd1;
         end
         re_hi_run++;
      end
      if (nand_ce_n && !ce_prev) ce_rises++;
      if (bdelay > 0) begin
         bdelay--;
         if (bdelay == 0 && blen > 0) rb_q <= 1'b0;
      end else if (!rb_q) begin
         if (blen <= 1) rb_q <= 1'b1;
         blen--;
      end
      we_prev = nand_we_n;
      re_prev = nand_re_n;
      ce_prev = nand_ce_n;
   end

   // ---------------- stream sink ----------------
   logic [7:0] rx [1200];
   int         rx_n = 0, done_n = 0, done_bad = 0;
   bit         bp_mode = 1'b0;
   logic [7:0] lfsr = 8'hA5;

   initial out_ready = 1'b1;

   always @(negedge clk) begin
      if (bp_mode) begin
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         out_ready = lfsr[0];
      end else begin
         out_ready = 1'b1;
      end
      if (out_valid && out_ready && rx_n < 1200) begin
         rx[rx_n] = out_data;
         rx_n++;
      end
      if (done) begin
         done_n++;
         if (!nand_ce_n) done_bad++;
      end
   end

   // watchdog
   always @(posedge clk) begin
      if (cyc == WDOG) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   // ---------------- test procedure ----------------
   logic [1:0]  ek [32];
   logic [7:0]  eb [32];
   logic [7:0]  erx [1200];
   int          en, erx_n;

   task automatic clear_stats();
      @(negedge clk);
      log_n = 0; rx_n = 0; done_n = 0; done_bad = 0;
      strobe_err = 0; busy_err = 0; ce_rises = 0; gap = -1; gap_pend = 1'b0;
   endtask

   task automatic run_vec(input vec_t v, input string tag);
      int ncol, nrow, sp, nerr, first_bad;
      logic [23:0] rmask;
      bit saw_ready;
      ncol = (v.ncol == 0) ? 1 : int'(v.ncol);
      nrow = (v.nrow == 0) ? 1 : int'(v.nrow);
      rmask = (nrow == 1) ? 24'h0000FF : (nrow == 2) ? 24'h00FFFF : 24'hFFFFFF;
      sp = int'(v.ps) / 32;
      en = 0; erx_n = 0;
      if (v.op == OP_ID) begin
         ek[0] = 2'd1; eb[0] = 8'h90;
         ek[1] = 2'd2; eb[1] = 8'h00;
         en = 2;
         for (int i = 0; i < 5; i++) erx[i] = idbyte(i);
         erx_n = 5;
      end else begin
         ek[en] = 2'd1; eb[en] = 8'h00; en++;
         for (int i = 0; i < ncol; i++) begin ek[en] = 2'd2; eb[en] = v.ps[8*i +: 8]; en++; end
         for (int i = 0; i < nrow; i++) begin ek[en] = 2'd2; eb[en] = v.row[8*i +: 8]; en++; end
         ek[en] = 2'd1; eb[en] = 8'h30; en++;
         for (int i = 0; i < sp; i++) begin
            erx[erx_n] = dbyte(v.row & rmask, v.ps + 16'(i)); erx_n++;
         end
         if (v.op == OP_PAGE) begin
            ek[en] = 2'd1; eb[en] = 8'h05; en++;
            ek[en] = 2'd2; eb[en] = 8'h00; en++;
            ek[en] = 2'd2; eb[en] = 8'h00; en++;
            ek[en] = 2'd1; eb[en] = 8'hE0; en++;
            for (int i = 0; i < int'(v.ps); i++) begin
               erx[erx_n] = dbyte(v.row & rmask, 16'(i)); erx_n++;
            end
         end
      end
      clear_stats();
      cur_ncol = ncol; cur_blen = int'(v.blen);
      exp_lo = (v.lo < 2) ? 2 : int'(v.lo);
      exp_hi = (v.hi < 2) ? 2 : int'(v.hi);
      bp_mode = v.bp;
      cfg_col_bytes = v.ncol; cfg_row_bytes = v.nrow; cfg_page_size = v.ps;
      cfg_strobe_low = v.lo; cfg_strobe_high = v.hi;
      req_op = v.op; req_row = v.row; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      saw_ready = 1'b0;
      for (int t = 0; t < 60000 && done_n == 0; t++) begin
         @(negedge clk);
         if (v.poke && t == 40) begin
            saw_ready = req_ready;
            req_op = OP_ID; req_valid = 1'b1;
         end else begin
            req_valid = 1'b0;
         end
      end
      repeat (40) @(negedge clk);
      bp_mode = 1'b0;
      repeat (10) @(negedge clk);
      // R1 R2 R5 R6 R8: command and address bytes with their latch enables
      nerr = 0; first_bad = -1;
      for (int i = 0; i < en && i < log_n; i++)
         if (log_k[i] != ek[i] || log_b[i] != eb[i]) begin
            nerr++;
            if (first_bad < 0) first_bad = i;
         end
      check(log_n == en, tag, "R1/R2 bus byte count", log_n, en);
      check(nerr == 0, tag, "R1 R2 R8 bus byte mismatches",
            (first_bad < 0) ? 0 : {log_k[first_bad], log_b[first_bad]},
            (first_bad < 0) ? 0 : {ek[first_bad], eb[first_bad]});
      // R4 R5 R6 R11: returned stream
      nerr = 0; first_bad = -1;
      for (int i = 0; i < erx_n && i < rx_n; i++)
         if (rx[i] != erx[i]) begin
            nerr++;
            if (first_bad < 0) first_bad = i;
         end
      check(rx_n == erx_n, tag, "R4/R5/R6/R11 stream length", rx_n, erx_n);
      check(nerr == 0, tag, "R4 R5 R6 R11 stream data",
            (first_bad < 0) ? 0 : rx[first_bad], (first_bad < 0) ? 0 : erx[first_bad]);
      // R9
      check(strobe_err == 0, tag, "R9 strobe width violations", strobe_err, 0);
      // R3
      check(busy_err == 0, tag, "R3 read strobe while busy", busy_err, 0);
      if (v.op != OP_ID && v.blen == 0)
         check(gap >= BUSY_POLLS, tag, "R3 busy window bound gap", gap, BUSY_POLLS);
      // R7
      check(ce_rises == 1 && done_n == 1 && done_bad == 0, tag,
            "R7 chip-enable releases / done pulses", ce_rises * 10 + done_n, 11);
      // R10
      if (v.poke) check(!saw_ready, tag, "R10 req_ready while busy", saw_ready, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset state
      check(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale,
            "R12", "bus idle in reset", {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale}, 5'b11100);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready && !out_valid && nand_ce_n, "R12", "after reset ready/valid/ce",
            {req_ready, out_valid, nand_ce_n}, 3'b101);

      for (int i = 0; i < NV; i++) run_vec(VECS[i], $sformatf("vec%0d", i));

      // R10: code 3 is not accepted
      clear_stats();
      req_op = 2'd3; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (20) @(negedge clk);
      check(log_n == 0 && ce_rises == 0 && done_n == 0 && req_ready && nand_ce_n,
            "R10", "op code 3 ignored", log_n + ce_rises + done_n, 0);

      // R12: reset during an operation returns the bus to idle
      req_op = OP_SPARE; req_row = 24'h000010; cfg_page_size = 16'd256;
      cur_blen = 50; exp_lo = 2; exp_hi = 2;
      cfg_strobe_low = 4'd2; cfg_strobe_high = 4'd2; cfg_col_bytes = 2'd2; cfg_row_bytes = 2'd3;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (15) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(nand_ce_n && nand_we_n && !nand_cle && !nand_ale && !out_valid,
            "R12", "mid-operation reset", {nand_ce_n, nand_we_n, nand_cle, nand_ale, out_valid}, 5'b11000);
      rst_n = 1'b1;
      repeat (80) @(negedge clk);
      check(req_ready, "R12", "idle after reset", req_ready, 1);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule